// File: doc/BRIEF.md
# Frame-Strobe Power Sequencer with Offset-Loop Bandwidth Control

This block sits beside a sampled-data converter and decides, from the presence of an external frame strobe (nominally 8 kHz), whether the chip is powered down, acquiring, or running. A free-running system clock times the gaps between strobe edges. When the gaps grow longer than a programmable limit, the strobe counts as gone and the chip is powered down. As soon as strobe edges return, the offset-cancelling integrator is powered up in its fast, wide-bandwidth setting. The block then waits for the phase-locked loop to report lock. After lock, it releases the chip enable and moves the integrator to its slow, narrow-bandwidth setting.

There are three named states. OFF drives `power_down`. ACQUIRE drives `az_wide`, with the chip not yet enabled. RUN drives `por_enable`, with the integrator narrow. The named transitions are as follows:
- **wake** (OFF to ACQUIRE): the strobe is present.
- **lock-gained** (ACQUIRE to RUN): the synchronised lock input is high and the strobe is present.
- **lock-lost** (RUN to ACQUIRE): the synchronised lock input is low and the strobe is present.
- **strobe-lost** (any state to OFF): the strobe is missing. This transition takes priority over every other transition.

Both the strobe and the lock input are asynchronous to the system clock. Each passes through a synchroniser before it is used.

Top module: `strobe_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until a strobe edge is detected, the block is in OFF: `power_down`=1, `az_wide`=0, `por_enable`=0.
- R2: `strobe` and `pll_lock` each pass through `SYNC_STAGES` (default 2) flip-flops, and a strobe rising edge is found by comparing the last stage with one more register. A strobe first sampled high at clock edge k, from OFF, gives `az_wide`=1 after edge k+3 and not before.
- R3: A counter is cleared by each detected strobe rising edge and then counts clock edges, saturating at `TIMEOUT_CYCLES`. While it holds `TIMEOUT_CYCLES` (also its reset value), the strobe is missing. After the clear, power-down follows `TIMEOUT_CYCLES`+1 edges later unless another edge arrives.
- R4: wake. In OFF with the strobe present, the next state is ACQUIRE (`az_wide`=1, `power_down`=0, `por_enable`=0), whatever the lock input is.
- R5: lock-gained. In ACQUIRE with the strobe present and synchronised lock high, the next state is RUN (`por_enable`=1, `az_wide`=0, `power_down`=0).
- R6: lock-lost. In RUN with the strobe present and synchronised lock low, the next state is ACQUIRE.
- R7: strobe-lost. In any state with the strobe missing, the next state is OFF, even when lock is high.
- R8: In OFF with no strobe edges, the lock input has no effect: `power_down` stays 1.
- R9: Every cycle exactly one of `power_down`, `az_wide` and `por_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | External frame strobe, asynchronous |
| pll_lock | input | 1 | Lock indication from the phase-locked loop, asynchronous |
| power_down | output | 1 | High in OFF: chip powered down |
| az_wide | output | 1 | High in ACQUIRE: integrator powered, wide bandwidth |
| por_enable | output | 1 | High in RUN: chip enabled, integrator narrow |

## Verification
The assertions assume that `strobe` and `pll_lock` hold each value for at least one full clock period, so the synchroniser sees every level. They also assume the strobe pulse is shorter than its period, so that each pulse gives exactly one detected rising edge. The stimulus meets both assumptions. It drives the inputs only on falling clock edges and keeps every strobe high for several clocks. It sweeps strobe periods below the timeout, just below it, and beyond it. It moves the lock input in every state, including OFF.

// File: rtl/strobe_pd_pkg.sv
package strobe_pd_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_RUN     = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/sync_stages.sv
module sync_stages #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/strobe_watch.sv
module strobe_watch #(
    parameter int TIMEOUT_CYCLES = 31250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    output logic strobe_ok
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    logic          strobe_prev;
    logic          rise;
    logic [CW-1:0] gap_cnt;

    assign rise      = strobe_s & ~strobe_prev;
    assign strobe_ok = (gap_cnt != LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev <= 1'b0;
            gap_cnt     <= LIMIT;
        end else begin
            strobe_prev <= strobe_s;
            if (rise)                 gap_cnt <= '0;
            else if (gap_cnt != LIMIT) gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (gap_cnt == '0)); // R3
    AST_ABSENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ok && !rise) |=> !strobe_ok); // R3
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import strobe_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_ok,
    input  logic lock_s,
    output logic power_down,
    output logic az_wide,
    output logic por_enable
);
    pwr_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (!strobe_ok) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     state_nx = ST_ACQUIRE;
                ST_ACQUIRE: state_nx = lock_s ? ST_RUN : ST_ACQUIRE;
                ST_RUN:     state_nx = lock_s ? ST_RUN : ST_ACQUIRE;
                default:    state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        power_down = 1'b0;
        az_wide    = 1'b0;
        por_enable = 1'b0;
        unique case (state)
            ST_OFF:     power_down = 1'b1;
            ST_ACQUIRE: az_wide    = 1'b1;
            ST_RUN:     por_enable = 1'b1;
            default:    power_down = 1'b1;
        endcase
    end

    AST_LOSS_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_ok |=> power_down); // R7
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (por_enable && strobe_ok && !lock_s) |=> az_wide); // R6
    AST_WAKE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_down) |-> az_wide); // R4
    AST_ENABLE_AFTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_enable) |-> $past(az_wide)); // R5
endmodule

// File: rtl/strobe_pwr_ctrl.sv
module strobe_pwr_ctrl #(
    parameter int TIMEOUT_CYCLES = 31250,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic pll_lock,
    output logic power_down,
    output logic az_wide,
    output logic por_enable
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] synced;
    logic             strobe_ok;

    assign raw_in = {pll_lock, strobe};

    sync_stages #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (synced)
    );

    strobe_watch #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_s  (synced[0]),
        .strobe_ok (strobe_ok)
    );

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_ok  (strobe_ok),
        .lock_s     (synced[1]),
        .power_down (power_down),
        .az_wide    (az_wide),
        .por_enable (por_enable)
    );
endmodule

// File: tb/strobe_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module strobe_pwr_ctrl_bench;
    localparam int T_OUT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic pll_lock = 1'b0;
    logic power_down, az_wide, por_enable;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    strobe_pwr_ctrl #(.TIMEOUT_CYCLES(T_OUT), .SYNC_STAGES(2)) u_strobe_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pll_lock(pll_lock),
        .power_down(power_down), .az_wide(az_wide), .por_enable(por_enable)
    );

    // Behavioural reference: sample histories and an expected mode (0 off, 1 acquire, 2 run)
    bit strobe_hist[$];
    bit lock_hist[$];
    bit seen_prev;
    int gap;
    int mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            strobe_hist = {1'b0, 1'b0};
            lock_hist   = {1'b0, 1'b0};
            seen_prev   = 1'b0;
            gap         = T_OUT;
            mode        = 0;
        end else begin
            bit edge_seen, lock_now, present;
            int next_mode;
            edge_seen = strobe_hist[0] && !seen_prev;
            lock_now  = lock_hist[0];
            present   = (gap < T_OUT);
            if (!present)      next_mode = 0;
            else if (mode == 0) next_mode = 1;
            else               next_mode = lock_now ? 2 : 1;
            seen_prev = strobe_hist[0];
            void'(strobe_hist.pop_front());
            strobe_hist.push_back(strobe);
            void'(lock_hist.pop_front());
            lock_hist.push_back(pll_lock);
            if (edge_seen)         gap = 0;
            else if (gap < T_OUT)  gap = gap + 1;
            mode = next_mode;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            int got, exp;
            got = {power_down, az_wide, por_enable};
            exp = (mode == 0) ? 4 : (mode == 1) ? 2 : 1;
            check($countones({power_down, az_wide, por_enable}) == 1, "R9", got, exp);
            if (mode == 0)      check(got == exp, "R7", got, exp);
            else if (mode == 1) check(got == exp, "R4", got, exp);
            else                check(got == exp, "R5", got, exp);
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int period, input int count);
        for (int p = 0; p < count; p++) begin
            strobe = 1'b1;
            idle(4);
            strobe = 1'b0;
            idle(period - 4);
        end
    endtask

    initial begin
        idle(3);
        check({power_down, az_wide, por_enable} == 3'b100, "R1", {power_down, az_wide, por_enable}, 4);
        rst_n = 1'b1;
        idle(5);
        check(power_down == 1'b1, "R1", power_down, 1);

        // R2 latency: strobe sampled high at edge k, az_wide after edge k+3
        strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(az_wide == 1'b0, "R2", az_wide, 0);
        @(posedge clk);
        @(negedge clk);
        check(az_wide == 1'b1, "R2", az_wide, 1);
        idle(2);
        strobe = 1'b0;
        idle(14);

        // Stay in acquire without lock
        pulses(24, 4);
        check(az_wide == 1'b1, "R4", az_wide, 1);
        // Lock arrives
        pll_lock = 1'b1;
        pulses(24, 3);
        check(por_enable == 1'b1, "R5", por_enable, 1);
        // Lock lost while strobe continues
        pll_lock = 1'b0;
        pulses(24, 2);
        check(az_wide == 1'b1, "R6", az_wide, 1);
        pll_lock = 1'b1;
        pulses(38, 4);
        check(por_enable == 1'b1, "R5", por_enable, 1);

        // Strobe stops while locked
        idle(T_OUT + 8);
        check(power_down == 1'b1, "R3", power_down, 1);
        check(power_down == 1'b1, "R7", power_down, 1);

        // Lock toggling in OFF has no effect
        pll_lock = 1'b0;
        idle(10);
        pll_lock = 1'b1;
        idle(30);
        check(power_down == 1'b1, "R8", power_down, 1);

        // Period beyond timeout: block drops out between pulses
        pulses(50, 5);
        pulses(24, 3);
        pll_lock = 1'b0;
        pulses(30, 3);
        pll_lock = 1'b1;
        pulses(20, 4);
        strobe = 1'b1;
        idle(T_OUT + 10);
        check(power_down == 1'b1, "R3", power_down, 1);
        strobe = 1'b0;
        idle(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule